// File: doc/BRIEF.md
# DMA Line-Chunking Request Sequencer

This block sits between a DMA requester and a memory port that only handles transactions inside one cache line. A request gives a byte address, a byte length and a direction. The block keeps it in a small table of active entries and walks it across the line grid one chunk at a time. The first chunk runs from the start address to the end of its line, or to the end of the request if that comes sooner. Every later chunk starts on a line boundary. Only one chunk of any request is outstanding at a time. The next chunk is offered after the memory port acknowledges a store or returns a line of load data.

The requester's data buffers are modelled as byte-lane ports. For stores, the block asks a source port for request bytes starting at a given request-relative offset, and places them in the chunk's lanes. For loads, the returned line is shifted so that byte 0 of a sink beat is the first requested byte, and it is presented with its request-relative offset and length. When the final chunk of a request is answered, the entry is released and a completion naming the slot is raised.

A request is refused with a full status when every slot is in use. It is refused with an aliased status when its start line equals the start line of any active entry. Refused requests leave all state unchanged. Responses carry the slot index. A response to an idle slot, or to a slot with no chunk in flight, sets a sticky error flag.

Top module: `dmaseq_chunker`

## Requirements
- R1: While the number of active entries equals SLOTS, a presented request gets req_status 2 (full) in the same cycle, and no entry is allocated.
- R2: When a request is not refused as full and its start line (address with the low log2(LINE_BYTES) bits dropped) equals the start line of any active entry, it gets req_status 2'd3 (aliased) and nothing is allocated.
- R3: Any other presented request gets req_status 1 (issued), with req_slot set to the lowest-numbered free slot. Its first chunk can be offered on the issue port from the next cycle. With no request presented, req_status is 0.
- R4: The first chunk of a request has iss_addr equal to the request address. Its iss_len is the request length when offset plus length is at most LINE_BYTES, and LINE_BYTES minus the offset otherwise.
- R5: Each later chunk has iss_addr equal to the start address plus the bytes completed so far, which is line aligned. Its iss_len is the smaller of the remaining bytes and LINE_BYTES.
- R6: iss_store is 1 for a write request. iss_be bit k is set exactly for lanes offset to offset+iss_len-1. For a store, data lane offset+j holds source byte j, where src_slot and src_off name the request and its bytes completed. Other lanes are zero, and all lanes are zero for loads.
- R7: An offered chunk stays offered with the same slot, address and length until iss_ready is sampled high. A request never has a second chunk offered before the response to the previous one.
- R8: One cycle after a response to an active load chunk, snk_valid is 1. snk_slot names the slot, snk_off is the bytes completed before that chunk, snk_len is the chunk length, and snk_data byte j is the memory byte at chunk address plus j.
- R9: One cycle after the response to a request's last chunk, done_valid pulses with done_slot. The slot is free from that edge, and a request arriving in the response cycle is judged against the table as it stood before the response.
- R10: A response to an inactive slot, or to a slot with no chunk in flight, sets err from the next cycle on, and err stays set until reset.
- R11: With no offer held, the issue port offers the chunk of the lowest-numbered slot that has one waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented this cycle |
| req_addr | input | ADDR_W | Request start byte address |
| req_len | input | LEN_W | Request length in bytes (at least 1) |
| req_write | input | 1 | 1 for a write (store) request |
| req_status | output | 2 | 0 none, 1 issued, 2 full, 3 aliased |
| req_slot | output | SLOT_W | Slot granted when issued |
| iss_valid | output | 1 | Chunk offered to memory |
| iss_ready | input | 1 | Memory accepts the offered chunk |
| iss_slot | output | SLOT_W | Slot of the offered chunk |
| iss_addr | output | ADDR_W | Chunk byte address |
| iss_len | output | LEN_W | Chunk length in bytes |
| iss_store | output | 1 | Chunk is a store |
| iss_be | output | LINE_BYTES | Lane enables within the line |
| iss_data | output | LINE_BYTES*8 | Store data in line lanes |
| src_slot | output | SLOT_W | Source buffer request selector |
| src_off | output | LEN_W | Source buffer request-relative offset |
| src_data | input | LINE_BYTES*8 | Source bytes from src_off upward |
| rsp_valid | input | 1 | Memory response |
| rsp_slot | input | SLOT_W | Slot the response belongs to |
| rsp_data | input | LINE_BYTES*8 | Full line of load data |
| snk_valid | output | 1 | Load bytes delivered to requester |
| snk_slot | output | SLOT_W | Slot of delivered bytes |
| snk_off | output | LEN_W | Request-relative offset of delivered bytes |
| snk_len | output | LEN_W | Number of valid delivered bytes |
| snk_data | output | LINE_BYTES*8 | Delivered bytes, first at byte 0 |
| done_valid | output | 1 | A request has finished |
| done_slot | output | SLOT_W | Slot of the finished request |
| err | output | 1 | Sticky unexpected-response flag |

## Verification
Admission and release can fall in the same cycle: a final-chunk response frees a slot on the same edge at which a new request is judged. The bench fills every slot with one-byte loads and holds their responses. It then answers one slot in the same cycle as a request for a fresh line, and expects full, because admission sees the table as it stood before the edge. A request for that freed line in the following cycle is expected to be issued into the same slot. A second case answers a slot's last chunk together with a request to another address in that slot's line, and expects aliased.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    ST_NONE    = 2'd0,
    ST_ISSUED  = 2'd1,
    ST_FULL    = 2'd2,
    ST_ALIASED = 2'd3
  } req_status_e;

  // Length of the opening chunk: trimmed at the end of the start line.
  function automatic int unsigned head_len(int unsigned off, int unsigned len,
                                           int unsigned line);
    return (off + len <= line) ? len : (line - off);
  endfunction

  // Length of any following chunk: at most a full line.
  function automatic int unsigned body_len(int unsigned rem, int unsigned line);
    return (rem < line) ? rem : line;
  endfunction

endpackage

// File: rtl/dmaseq_lowest.sv
module dmaseq_lowest #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |vec_i;

endmodule

// File: rtl/dmaseq_slot.sv
module dmaseq_slot
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [LEN_W-1:0]  alloc_len_i,
  input  logic              alloc_write_i,
  input  logic              issue_i,
  input  logic              rsp_i,
  output logic              active_o,
  output logic              need_o,
  output logic              write_o,
  output logic [LINE_W-1:0] line_o,
  output logic [ADDR_W-1:0] chunk_addr_o,
  output logic [LEN_W-1:0]  chunk_len_o,
  output logic [LEN_W-1:0]  done_off_o,
  output logic [LEN_W-1:0]  inflight_o,
  output logic              last_o,
  output logic              bad_o
);

  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q, sent_q, done_q;
  logic              active_q, need_q, write_q;

  // Named events for the assertions below
  logic is_first, chunk_misaligned;

  assign is_first = (done_q == '0);

  always_comb begin
    if (is_first)
      chunk_len_o = LEN_W'(head_len(32'(start_q[OFF_W-1:0]), 32'(len_q), LINE_BYTES));
    else
      chunk_len_o = LEN_W'(body_len(32'(len_q - done_q), LINE_BYTES));
  end

  assign chunk_addr_o     = start_q + ADDR_W'(done_q);
  assign chunk_misaligned = (chunk_addr_o[OFF_W-1:0] != '0);
  assign active_o         = active_q;
  assign need_o           = need_q;
  assign write_o          = write_q;
  assign line_o           = start_q[ADDR_W-1:OFF_W];
  assign done_off_o       = done_q;
  assign inflight_o       = sent_q - done_q;
  assign last_o           = (sent_q == len_q);
  assign bad_o            = !active_q || (sent_q == done_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      need_q   <= 1'b0;
      write_q  <= 1'b0;
      start_q  <= '0;
      len_q    <= '0;
      sent_q   <= '0;
      done_q   <= '0;
    end else if (alloc_i) begin
      active_q <= 1'b1;
      need_q   <= 1'b1;
      write_q  <= alloc_write_i;
      start_q  <= alloc_addr_i;
      len_q    <= alloc_len_i;
      sent_q   <= '0;
      done_q   <= '0;
    end else begin
      if (issue_i) begin
        sent_q <= sent_q + chunk_len_o;
        need_q <= 1'b0;
      end
      if (rsp_i) begin
        done_q <= sent_q;
        if (sent_q == len_q) active_q <= 1'b0;
        else                 need_q   <= 1'b1;
      end
    end
  end

  // R5: chunks after the first start on a line boundary
  assert_later_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && need_q && !is_first) |-> !chunk_misaligned);

  // R7: the issue strobe only lands on a slot that is waiting and has nothing in flight
  assert_one_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> (need_q && active_q && sent_q == done_q));

  // R9: an answered last chunk frees the slot on that edge
  assert_free_on_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_i && last_o) |=> !active_o);

endmodule

// File: rtl/dmaseq_chunker.sv
module dmaseq_chunker
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16,
  parameter int SLOTS      = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int DATA_W    = LINE_BYTES * 8,
  localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W     = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  output logic [1:0]        req_status,
  output logic [SLOT_W-1:0] req_slot,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [SLOT_W-1:0] iss_slot,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [LEN_W-1:0]  iss_len,
  output logic              iss_store,
  output logic [LINE_BYTES-1:0] iss_be,
  output logic [DATA_W-1:0] iss_data,
  output logic [SLOT_W-1:0] src_slot,
  output logic [LEN_W-1:0]  src_off,
  input  logic [DATA_W-1:0] src_data,
  input  logic              rsp_valid,
  input  logic [SLOT_W-1:0] rsp_slot,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              snk_valid,
  output logic [SLOT_W-1:0] snk_slot,
  output logic [LEN_W-1:0]  snk_off,
  output logic [LEN_W-1:0]  snk_len,
  output logic [DATA_W-1:0] snk_data,
  output logic              done_valid,
  output logic [SLOT_W-1:0] done_slot,
  output logic              err
);

  // Per-slot views
  logic [SLOTS-1:0]  act_v, need_v, wr_v, last_v, bad_v, alias_v;
  logic [LINE_W-1:0] line_a  [SLOTS];
  logic [ADDR_W-1:0] caddr_a [SLOTS];
  logic [LEN_W-1:0]  clen_a  [SLOTS];
  logic [LEN_W-1:0]  doff_a  [SLOTS];
  logic [LEN_W-1:0]  infl_a  [SLOTS];

  // Named internal events
  logic              full, alias_hit, accept, iss_fire, rsp_ok, rsp_fin, dup_line;
  logic              free_any, need_any;
  logic [SLOT_W-1:0] free_idx, need_idx, pick;
  logic [CNT_W-1:0]  cnt_q;
  logic              hold_q;
  logic [SLOT_W-1:0] hold_slot_q;
  req_status_e       status;
  logic [OFF_W-1:0]  lane_lo;
  logic [DATA_W-1:0] src_shift;

  // ---------------- admission ----------------
  assign full      = (cnt_q == CNT_W'(SLOTS));
  assign alias_hit = |alias_v;

  always_comb begin
    if (!req_valid)     status = ST_NONE;
    else if (full)      status = ST_FULL;
    else if (alias_hit) status = ST_ALIASED;
    else                status = ST_ISSUED;
  end

  assign accept     = (status == ST_ISSUED);
  assign req_status = status;
  assign req_slot   = free_idx;

  dmaseq_lowest #(.N(SLOTS), .W(SLOT_W)) u_free (
    .vec_i(~act_v), .any_o(free_any), .idx_o(free_idx));

  // ---------------- slot table ----------------
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    dmaseq_slot #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (accept && (free_idx == SLOT_W'(g))),
      .alloc_addr_i (req_addr),
      .alloc_len_i  (req_len),
      .alloc_write_i(req_write),
      .issue_i      (iss_fire && (pick == SLOT_W'(g))),
      .rsp_i        (rsp_ok && (rsp_slot == SLOT_W'(g))),
      .active_o     (act_v[g]),
      .need_o       (need_v[g]),
      .write_o      (wr_v[g]),
      .line_o       (line_a[g]),
      .chunk_addr_o (caddr_a[g]),
      .chunk_len_o  (clen_a[g]),
      .done_off_o   (doff_a[g]),
      .inflight_o   (infl_a[g]),
      .last_o       (last_v[g]),
      .bad_o        (bad_v[g])
    );
    assign alias_v[g] = act_v[g] && (line_a[g] == req_addr[ADDR_W-1:OFF_W]);
  end

  always_comb begin
    dup_line = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      for (int j = i + 1; j < SLOTS; j++)
        if (act_v[i] && act_v[j] && line_a[i] == line_a[j]) dup_line = 1'b1;
  end

  // ---------------- issue port ----------------
  dmaseq_lowest #(.N(SLOTS), .W(SLOT_W)) u_need (
    .vec_i(need_v), .any_o(need_any), .idx_o(need_idx));

  assign pick      = hold_q ? hold_slot_q : need_idx;
  assign iss_valid = hold_q || need_any;
  assign iss_fire  = iss_valid && iss_ready;
  assign iss_slot  = pick;
  assign iss_addr  = caddr_a[pick];
  assign iss_len   = clen_a[pick];
  assign iss_store = wr_v[pick];
  assign src_slot  = pick;
  assign src_off   = doff_a[pick];
  assign lane_lo   = iss_addr[OFF_W-1:0];
  assign src_shift = src_data << {lane_lo, 3'b000};

  always_comb begin
    for (int k = 0; k < LINE_BYTES; k++) begin
      iss_be[k] = (k >= int'(lane_lo)) && (k < int'(lane_lo) + int'(iss_len));
      iss_data[k*8 +: 8] = (iss_store && iss_be[k]) ? src_shift[k*8 +: 8] : 8'h00;
    end
  end

  // ---------------- response path ----------------
  assign rsp_ok  = rsp_valid && !bad_v[rsp_slot];
  assign rsp_fin = rsp_ok && last_v[rsp_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      hold_q      <= 1'b0;
      hold_slot_q <= '0;
      err         <= 1'b0;
      done_valid  <= 1'b0;
      done_slot   <= '0;
      snk_valid   <= 1'b0;
      snk_slot    <= '0;
      snk_off     <= '0;
      snk_len     <= '0;
      snk_data    <= '0;
    end else begin
      cnt_q       <= cnt_q + CNT_W'(accept) - CNT_W'(rsp_fin);
      hold_q      <= iss_valid && !iss_ready;
      hold_slot_q <= pick;
      if (rsp_valid && bad_v[rsp_slot]) err <= 1'b1;
      done_valid  <= rsp_fin;
      done_slot   <= rsp_slot;
      snk_valid   <= rsp_ok && !wr_v[rsp_slot];
      snk_slot    <= rsp_slot;
      snk_off     <= doff_a[rsp_slot];
      snk_len     <= infl_a[rsp_slot];
      snk_data    <= rsp_data >> {caddr_a[rsp_slot][OFF_W-1:0], 3'b000};
    end
  end

  // ---------------- assertions ----------------
  // R1: the occupancy counter never passes the table size
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SLOTS));

  // R2: admission never leaves two active entries on one start line
  assert_unique_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_line);

  // R3: an issued grant always targets a slot that was free
  assert_grant_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (free_any && !act_v[free_idx]));

  // R4: an offered chunk is non-empty and stays inside its line
  assert_chunk_in_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_len != '0 && int'(lane_lo) + int'(iss_len) <= LINE_BYTES));

  // R7: an unaccepted offer is held unchanged
  assert_offer_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_slot) &&
                                   $stable(iss_addr) && $stable(iss_len)));

  // R9: the counter agrees with the slot flags
  assert_count_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) == $countones(act_v));

  // R10: once raised, the error flag stays raised
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: tb/sim_dmaseq_chunker.sv
module sim_dmaseq_chunker;
  localparam int AW = 32, LW = 12, LB = 16, NS = 4, SW = 2, DW = LB * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_write = 0, iss_ready = 0, rsp_valid = 0;
  logic [AW-1:0] req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic [1:0]    req_status;
  logic [SW-1:0] req_slot, iss_slot, src_slot, snk_slot, done_slot;
  logic [SW-1:0] rsp_slot = 0;
  logic          iss_valid, iss_store, snk_valid, done_valid, err;
  logic [AW-1:0] iss_addr;
  logic [LW-1:0] iss_len, src_off, snk_off, snk_len;
  logic [LB-1:0] iss_be;
  logic [DW-1:0] iss_data, src_data, snk_data;
  logic [DW-1:0] rsp_data = 0;

  dmaseq_chunker #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB), .SLOTS(NS)) u0 (.*);

  // requester write buffers: byte at request offset o of slot s is seed_a[s]+o
  int unsigned seed_a [NS];
  always_comb
    for (int k = 0; k < LB; k++)
      src_data[k*8 +: 8] = 8'(seed_a[src_slot] + int'(src_off) + k);

  function automatic logic [7:0] memb(int unsigned a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [DW-1:0] line_of(int unsigned a);
    logic [DW-1:0] d;
    for (int j = 0; j < LB; j++) d[j*8 +: 8] = memb((a / LB) * LB + j);
    return d;
  endfunction

  typedef struct { int slot; int unsigned addr; } pend_t;
  pend_t pq[$];

  // reference model
  bit m_act[NS], m_need[NS], m_wr[NS];
  int unsigned m_start[NS];
  int m_len[NS], m_iss[NS], m_cmp[NS];
  bit m_hold; int m_hold_slot;
  bit e_done, e_snk, e_err; int e_done_slot, e_snk_slot, e_snk_off, e_snk_len;
  logic [DW-1:0] e_snk_data;

  // stimulus controls
  bit n_req, n_wr, auto_rsp, rnd_ready, f_rsp; int unsigned n_addr; int n_len, f_slot;
  int unsigned seed_ctr = 11;
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [255:0] a,
                     input logic [255:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, a, e);
    end
  endtask

  function automatic int active_cnt();
    int c = 0;
    for (int i = 0; i < NS; i++) c += int'(m_act[i]);
    return c;
  endfunction

  task automatic step();
    int est, fr, p, ln, off, rs;
    int unsigned ad;
    bit al;
    logic [DW-1:0] ed, sd;
    logic [LB-1:0] eb;
    string t;
    @(negedge clk);
    req_valid = n_req; req_addr = n_addr; req_len = LW'(n_len); req_write = n_wr;
    iss_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
    rsp_valid = 0; rsp_slot = 0; rsp_data = 0; rs = -1;
    if (f_rsp) rs = f_slot;
    else if (auto_rsp && pq.size() > 0 && ($urandom % 3) == 0) rs = pq[$urandom % pq.size()].slot;
    if (rs >= 0) begin
      rsp_valid = 1; rsp_slot = SW'(rs);
      foreach (pq[i]) if (pq[i].slot == rs) rsp_data = line_of(pq[i].addr);
    end
    #1;
    // admission (R1 full, R2 aliased, R3 issued)
    est = 0; fr = -1;
    if (n_req) begin
      al = 0;
      for (int i = 0; i < NS; i++) if (m_act[i] && m_start[i] / LB == n_addr / LB) al = 1;
      est = (active_cnt() == NS) ? 2 : al ? 3 : 1;
      for (int i = NS - 1; i >= 0; i--) if (!m_act[i]) fr = i;
    end
    t = (est == 2) ? "R1" : (est == 3) ? "R2" : "R3";
    chk(t, "req_status", req_status, est);
    if (est == 1) chk("R3", "req_slot", req_slot, fr);
    // issue port (R4..R7, R11)
    p = -1;
    if (m_hold) p = m_hold_slot;
    else for (int i = NS - 1; i >= 0; i--) if (m_need[i]) p = i;
    chk("R7", "iss_valid", iss_valid, p >= 0);
    ln = 0; ad = 0;
    if (p >= 0) begin
      if (m_cmp[p] == 0) begin
        off = m_start[p] % LB; ad = m_start[p];
        ln = (off + m_len[p] <= LB) ? m_len[p] : LB - off; t = "R4";
      end else begin
        ad = m_start[p] + m_cmp[p];
        ln = (m_len[p] - m_cmp[p] < LB) ? m_len[p] - m_cmp[p] : LB; t = "R5";
      end
      off = ad % LB; ed = 0; eb = 0;
      for (int k = 0; k < LB; k++)
        if (k >= off && k < off + ln) begin
          eb[k] = 1;
          if (m_wr[p]) ed[k*8 +: 8] = 8'(seed_a[p] + m_cmp[p] + k - off);
        end
      chk("R11", "iss_slot", iss_slot, p);
      chk(t, "iss_addr", iss_addr, ad);
      chk(t, "iss_len", iss_len, ln);
      chk("R6", "iss_store", iss_store, m_wr[p]);
      chk("R6", "iss_be", iss_be, eb);
      chk("R6", "iss_data", iss_data, ed);
    end
    // registered outputs
    chk("R9", "done_valid", done_valid, e_done);
    if (e_done) chk("R9", "done_slot", done_slot, e_done_slot);
    chk("R8", "snk_valid", snk_valid, e_snk);
    if (e_snk) begin
      sd = snk_data;
      for (int k = 0; k < LB; k++) if (k >= e_snk_len) sd[k*8 +: 8] = 8'h00;
      chk("R8", "snk_slot", snk_slot, e_snk_slot);
      chk("R8", "snk_off", snk_off, e_snk_off);
      chk("R8", "snk_len", snk_len, e_snk_len);
      chk("R8", "snk_data", sd, e_snk_data);
    end
    chk("R10", "err", err, e_err);
    // model update: response (pre-edge state), then issue, then admission
    e_done = 0; e_snk = 0;
    if (rs >= 0) begin
      if (!m_act[rs] || m_iss[rs] == m_cmp[rs]) e_err = 1;
      else begin
        foreach (pq[i]) if (pq[i].slot == rs) begin pq.delete(i); break; end
        if (!m_wr[rs]) begin
          e_snk = 1; e_snk_slot = rs; e_snk_off = m_cmp[rs]; e_snk_len = m_iss[rs] - m_cmp[rs];
          e_snk_data = 0;
          for (int k = 0; k < e_snk_len; k++) e_snk_data[k*8 +: 8] = memb(m_start[rs] + m_cmp[rs] + k);
        end
        m_cmp[rs] = m_iss[rs];
        if (m_cmp[rs] == m_len[rs]) begin m_act[rs] = 0; e_done = 1; e_done_slot = rs; end
        else m_need[rs] = 1;
      end
    end
    if (p >= 0 && iss_ready) begin
      pq.push_back('{slot: p, addr: ad});
      m_iss[p] += ln; m_need[p] = 0;
    end
    m_hold = (p >= 0) && !iss_ready; m_hold_slot = p;
    if (est == 1) begin
      m_act[fr] = 1; m_need[fr] = 1; m_wr[fr] = n_wr; m_start[fr] = n_addr;
      m_len[fr] = n_len; m_iss[fr] = 0; m_cmp[fr] = 0;
      seed_a[fr] = seed_ctr; seed_ctr += 37;
    end
    n_req = 0; f_rsp = 0;
  endtask

  task automatic request(input int unsigned a, input int l, input bit w);
    n_req = 1; n_addr = a; n_len = l; n_wr = w; step();
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && active_cnt() != 0; i++) step();
    step(); step();
  endtask

  initial begin
    auto_rsp = 1; rnd_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();                                   // reset state: all outputs idle
    // R4/R5/R6: write spanning three lines, then loads
    request(32'h105, 40, 1); drain();
    request(32'h233, 7, 0); request(32'h3FA, 30, 0); drain();
    // collision cases with held responses (R1, R2, R9)
    auto_rsp = 0; rnd_ready = 0;
    for (int i = 0; i < NS; i++) request(32'h400 + i * LB, 1, 0);
    repeat (4) step();
    request(32'h438, 1, 0);                   // R2 aliased with slot 3
    f_rsp = 1; f_slot = 2; request(32'h500, 2, 0);  // R1 full despite release in same cycle
    request(32'h420, 3, 1);                   // R9 freed line reusable -> slot 2
    f_rsp = 1; f_slot = 0; step();
    f_rsp = 1; f_slot = 1; request(32'h41C, 1, 0);  // R2 releasing entry still blocks its line
    repeat (3) step();
    auto_rsp = 1; rnd_ready = 1; drain();
    // random traffic (R3, R7, R8, R11)
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 4) == 0) begin
        n_req = 1; n_addr = 32'h1000 + ($urandom % 12) * LB + ($urandom % LB);
        n_len = 1 + $urandom % 50; n_wr = 1'($urandom % 2);
      end
      step();
    end
    drain();
    // R10: stray response to an idle slot
    f_rsp = 1; f_slot = 1; step();
    step(); step();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule